// File: doc/BRIEF.md
# One-to-Seven Serial Link Deserializer

This block sits behind the input receivers of a narrow serial display link. It gathers four data lanes and one framing lane, all sampled on a bit clock that runs at seven times the word rate. From them it rebuilds a 28-bit parallel word once per word period. The framing lane carries a fixed seven-slot shape in every word. The block searches the incoming stream for that shape, and once it has seen the shape at the same offset for enough consecutive words it declares lock. From then on it delivers each assembled word together with a recovered word clock.

The recovered word clock is shaped for a falling-edge strobe. Each new word appears one bit clock after the clock rises. The word then holds through the low phase, so a downstream register that samples on the falling edge sees stable data. An active-low power-down input stops all activity, clears the alignment and forces every output low. Both the word rate (20 to 65 MHz) and the bit clock come from outside the block.

Top module: `dsr_link_rx`

## Requirements
- R1: While locked, the slot sampled j-th (j = 0..6, slot 0 first in time) of data lane k appears on `word_o` bit 7k+j of the word delivered for that period.
- R2: `locked_o` rises only after the framing lane has carried the slot shape 1,1,0,0,0,1,1 (slot 0 to slot 6) at the same word offset for 4 consecutive words, and not before the 4th.
- R3: While `locked_o` is low, `word_o` is all zero and `word_clk_o` is low.
- R4: While locked, a single word without the framing shape is tolerated and its data is still delivered. A second consecutive such word drops lock, clears the outputs and restarts the search.
- R5: `word_o` changes only in the bit-clock cycle after a word boundary, and it is stable whenever `word_clk_o` is low.
- R6: While locked, `word_clk_o` is high for the boundary cycle and the three cycles after it, and low for the remaining three cycles of each seven-cycle period.
- R7: One bit clock after `pwr_n` goes low, `word_o`, `word_clk_o` and `locked_o` are low. After release, lock again needs 4 fresh framed words.
- R8: The first word delivered after lock is the word that follows the 4th framed word. Each word appears on `word_o` one bit clock after its last slot is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, seven cycles per word |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down |
| frame_ser | input | 1 | Serial framing lane |
| data_ser | input | LANES (4) | Serial data lanes |
| word_o | output | LANES*SLOTS (28) | Rebuilt parallel word |
| word_clk_o | output | 1 | Recovered word clock, data stable across its falling edge |
| locked_o | output | 1 | Alignment lock flag |

## Verification
The assertions assume that the serial inputs change only between bit-clock edges. They also assume that the framing lane, once aligned, keeps a single word offset, so a valid framing shape never appears at a second offset while the block is aligning or locked. The stimulus always sends whole seven-slot words from the same phase. Words with missing framing are sent as an all-zero framing lane, which cannot form the shape at any shifted offset when it sits next to real framed words. Power-down is applied and released only on word starts, so the search after release begins from a clean window.

// File: rtl/dsr_pkg.sv
// Package: shared types and defaults for the serial link deserializer.
// Assumes a framing shape that has no match at any rotation except zero.
package dsr_pkg;

    // Alignment state of the framing search.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_LOCK  = 2'd2
    } align_st_t;

    // Default framing shape; bit j is slot j (slot 0 first in time).
    localparam logic [6:0] FRAME_SHAPE_DEF = 7'b1100011;

endpackage

// File: rtl/dsr_lane_shift.sv
// Module: one serial lane shifter.
// Collects the most recent SLOTS bits. The newest bit enters at the top,
// so after a whole word bit j holds slot j. A clear input empties the
// window (used for power-down).
module dsr_lane_shift #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ser_i,
    output logic [SLOTS-1:0] win_o
);

    logic [SLOTS-1:0] win_q;

    // Shift one bit per bit clock, newest at the most significant end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win_q <= '0;
        end else begin
            win_q <= {ser_i, win_q[SLOTS-1:1]};
        end
    end

    assign win_o = win_q;

endmodule

// File: rtl/dsr_frame_align.sv
// Module: framing search and lock tracking.
// Hunts for the framing shape at every bit position. Once found, it fixes
// the slot counter to that offset and counts consecutive hits at word
// boundaries. It declares lock after LOCK_WORDS hits and drops it after
// MISS_LIMIT consecutive misses. Power-down forces a fresh hunt.
// Assumes the framing window comes from a dsr_lane_shift of SLOTS bits.
module dsr_frame_align
    import dsr_pkg::*;
#(
    parameter int               SLOTS      = 7,
    parameter int               LOCK_WORDS = 4,
    parameter int               MISS_LIMIT = 2,
    parameter logic [SLOTS-1:0] SHAPE      = FRAME_SHAPE_DEF,
    localparam int              CNT_W      = $clog2(SLOTS),
    localparam int              MC_W       = $clog2(LOCK_WORDS + 1),
    localparam int              MS_W       = $clog2(MISS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic [SLOTS-1:0] frame_win,
    output logic             hit_o,
    output logic             bound_o,
    output logic [CNT_W-1:0] slot_cnt_o,
    output logic             lock_q_o,
    output logic             lock_d_o
);

    align_st_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_wrap;
    logic [MC_W-1:0]  mc_q, mc_d;
    logic [MS_W-1:0]  ms_q, ms_d;
    logic             hit;
    logic             at_bound;

    // Window matches the framing shape in slot order.
    assign hit      = (frame_win == SHAPE);
    assign at_bound = (cnt_q == '0);
    assign cnt_wrap = (cnt_q == CNT_W'(SLOTS - 1)) ? '0 : cnt_q + 1'b1;

    // Next-state logic for the search, alignment and lock tracking.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        mc_d  = mc_q;
        ms_d  = ms_q;
        if (!pwr_n) begin
            st_d  = ST_HUNT;
            cnt_d = '0;
            mc_d  = '0;
            ms_d  = '0;
        end else begin
            unique case (st_q)
                ST_HUNT: begin
                    if (hit) begin
                        st_d  = ST_ALIGN;
                        cnt_d = CNT_W'(1);
                        mc_d  = MC_W'(1);
                    end
                end
                ST_ALIGN: begin
                    cnt_d = cnt_wrap;
                    if (at_bound) begin
                        if (hit) begin
                            if (mc_q == MC_W'(LOCK_WORDS - 1)) begin
                                st_d = ST_LOCK;
                                ms_d = '0;
                            end else begin
                                mc_d = mc_q + 1'b1;
                            end
                        end else begin
                            st_d  = ST_HUNT;
                            cnt_d = '0;
                            mc_d  = '0;
                        end
                    end
                end
                ST_LOCK: begin
                    cnt_d = cnt_wrap;
                    if (at_bound) begin
                        if (hit) begin
                            ms_d = '0;
                        end else if (ms_q == MS_W'(MISS_LIMIT - 1)) begin
                            st_d  = ST_HUNT;
                            cnt_d = '0;
                            mc_d  = '0;
                            ms_d  = '0;
                        end else begin
                            ms_d = ms_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d  = ST_HUNT;
                    cnt_d = '0;
                    mc_d  = '0;
                    ms_d  = '0;
                end
            endcase
        end
    end

    // State registers for the alignment tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
            mc_q  <= '0;
            ms_q  <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            mc_q  <= mc_d;
            ms_q  <= ms_d;
        end
    end

    assign hit_o      = hit;
    assign bound_o    = at_bound && (st_q != ST_HUNT);
    assign slot_cnt_o = cnt_q;
    assign lock_q_o   = (st_q == ST_LOCK);
    assign lock_d_o   = (st_d == ST_LOCK);

endmodule

// File: rtl/dsr_word_out.sv
// Module: output word register and recovered word clock.
// Loads the assembled word only at a word boundary while lock holds on
// both sides of the edge. It clears the word when lock is about to drop.
// The word clock is registered and is high for slots 0..HIGH_SLOTS-1, so
// the data change (slot 1) sits well away from the falling edge.
module dsr_word_out #(
    parameter int  SLOTS      = 7,
    parameter int  WORD_W     = 28,
    localparam int CNT_W      = $clog2(SLOTS),
    localparam int HIGH_SLOTS = (SLOTS + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              bound_i,
    input  logic [CNT_W-1:0]  slot_cnt_i,
    input  logic              lock_q_i,
    input  logic              lock_d_i,
    output logic [WORD_W-1:0] word_o,
    output logic              wclk_o
);

    logic [WORD_W-1:0] word_q;
    logic              wclk_q;
    logic [CNT_W-1:0]  cnt_nxt;

    assign cnt_nxt = (slot_cnt_i == CNT_W'(SLOTS - 1)) ? '0 : slot_cnt_i + 1'b1;

    // Whole-word capture; clear whenever lock will not hold next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_d_i) begin
            word_q <= '0;
        end else if (bound_i && lock_q_i) begin
            word_q <= word_i;
        end
    end

    // Registered word clock derived from the upcoming slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
        end else begin
            wclk_q <= lock_d_i && (cnt_nxt < CNT_W'(HIGH_SLOTS));
        end
    end

    assign word_o = word_q;
    assign wclk_o = wclk_q;

endmodule

// File: rtl/dsr_link_rx.sv
// Module: top of the one-to-seven serial link deserializer.
// Instantiates one shifter per data lane plus one for the framing lane.
// The data lanes are concatenated so that lane k fills word bits
// k*SLOTS .. k*SLOTS+SLOTS-1. The framing tracker and output stage
// are wired on top of that.
// Assumes all serial inputs are already sampled on clk_bit at the right phase.
module dsr_link_rx
    import dsr_pkg::*;
#(
    parameter int  LANES      = 4,
    parameter int  SLOTS      = 7,
    parameter int  LOCK_WORDS = 4,
    parameter int  MISS_LIMIT = 2,
    localparam int WORD_W     = LANES * SLOTS,
    localparam int CNT_W      = $clog2(SLOTS)
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              frame_ser,
    input  logic [LANES-1:0]  data_ser,
    output logic [WORD_W-1:0] word_o,
    output logic              word_clk_o,
    output logic              locked_o
);

    logic [SLOTS-1:0]  frame_win;
    logic [WORD_W-1:0] word_bus;
    logic              frame_hit;
    logic              bound;
    logic [CNT_W-1:0]  slot_cnt;
    logic              lock_q;
    logic              lock_d;

    // One shifter per data lane, placed into its slice of the word.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dsr_lane_shift #(.SLOTS(SLOTS)) i_shift (
            .clk   (clk_bit),
            .rst_n (rst_n),
            .clr   (!pwr_n),
            .ser_i (data_ser[k]),
            .win_o (word_bus[k*SLOTS +: SLOTS])
        );
    end

    dsr_lane_shift #(.SLOTS(SLOTS)) i_frame_shift (
        .clk   (clk_bit),
        .rst_n (rst_n),
        .clr   (!pwr_n),
        .ser_i (frame_ser),
        .win_o (frame_win)
    );

    dsr_frame_align #(
        .SLOTS      (SLOTS),
        .LOCK_WORDS (LOCK_WORDS),
        .MISS_LIMIT (MISS_LIMIT),
        .SHAPE      (SLOTS'(FRAME_SHAPE_DEF))
    ) i_align (
        .clk        (clk_bit),
        .rst_n      (rst_n),
        .pwr_n      (pwr_n),
        .frame_win  (frame_win),
        .hit_o      (frame_hit),
        .bound_o    (bound),
        .slot_cnt_o (slot_cnt),
        .lock_q_o   (lock_q),
        .lock_d_o   (lock_d)
    );

    dsr_word_out #(
        .SLOTS  (SLOTS),
        .WORD_W (WORD_W)
    ) i_out (
        .clk        (clk_bit),
        .rst_n      (rst_n),
        .word_i     (word_bus),
        .bound_i    (bound),
        .slot_cnt_i (slot_cnt),
        .lock_q_i   (lock_q),
        .lock_d_i   (lock_d),
        .word_o     (word_o),
        .wclk_o     (word_clk_o)
    );

    assign locked_o = lock_q;

endmodule

// File: rtl/dsr_link_rx_chk.sv
// Module: property checker for dsr_link_rx, attached by bind below.
// Assumes a single framing offset while aligned (see the brief).
module dsr_link_rx_chk #(
    parameter int WORD_W = 28
) (
    input logic              clk_bit,
    input logic              rst_n,
    input logic              pwr_n,
    input logic [WORD_W-1:0] word_o,
    input logic              word_clk_o,
    input logic              locked_o,
    input logic              frame_hit
);

    // R2: lock can only be entered right after a framing hit.
    a_r2_lock_after_hit: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(locked_o) |-> $past(frame_hit));

    // R3: no data and no word clock without lock.
    a_r3_quiet_unlocked: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !locked_o |-> (word_o == '0) && !word_clk_o);

    // R5: the word holds while the word clock is low.
    a_r5_hold_low_phase: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (locked_o && !word_clk_o) |-> $stable(word_o));

    // R6: the low phase lasts at least three bit clocks.
    a_r6_low_phase: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $fell(word_clk_o) |=> !word_clk_o ##1 !word_clk_o);

    // R7: power-down silences every output one bit clock later.
    a_r7_pd_quiet: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pwr_n |=> (word_o == '0) && !word_clk_o && !locked_o);

endmodule

bind dsr_link_rx dsr_link_rx_chk #(.WORD_W(LANES * SLOTS)) i_dsr_chk (
    .clk_bit    (clk_bit),
    .rst_n      (rst_n),
    .pwr_n      (pwr_n),
    .word_o     (word_o),
    .word_clk_o (word_clk_o),
    .locked_o   (locked_o),
    .frame_hit  (frame_hit)
);

// File: tb/test_dsr_link_rx.sv
// Bench: drives whole seven-slot words and checks the outputs against a
// word-level model written from the requirements.
module test_dsr_link_rx;

    localparam int         LANES = 4;
    localparam int         SLOTS = 7;
    localparam int         W     = LANES * SLOTS;
    localparam logic [6:0] SHAPE = 7'b1100011;
    localparam logic [6:0] NOSHAPE = 7'b0000000;

    logic             clk_bit = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_n = 1'b1;
    logic             frame_ser = 1'b0;
    logic [LANES-1:0] data_ser = '0;
    logic [W-1:0]     word_o;
    logic             word_clk_o;
    logic             locked_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Word-level model state.
    logic         m_lock  = 1'b0;
    int           m_match = 0;
    int           m_miss  = 0;
    logic [W-1:0] m_word  = '0;
    string        ptag    = "R1";

    dsr_link_rx i_dsr_link_rx (
        .clk_bit    (clk_bit),
        .rst_n      (rst_n),
        .pwr_n      (pwr_n),
        .frame_ser  (frame_ser),
        .data_ser   (data_ser),
        .word_o     (word_o),
        .word_clk_o (word_clk_o),
        .locked_o   (locked_o)
    );

    always #2 clk_bit = ~clk_bit;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one received word at its boundary.
    task automatic model_word(input logic [6:0] pat, input logic [W-1:0] data);
        if (!m_lock) begin
            m_word = '0;
            if (pat == SHAPE) begin
                m_match++;
                if (m_match == 4) begin
                    m_lock = 1'b1;
                    m_miss = 0;
                end
            end else begin
                m_match = 0;
            end
        end else if (pat == SHAPE) begin
            m_miss = 0;
            m_word = data;
        end else begin
            m_miss++;
            if (m_miss == 2) begin
                m_lock  = 1'b0;
                m_match = 0;
                m_miss  = 0;
                m_word  = '0;
            end else begin
                m_word = data;
            end
        end
    endtask

    // Send one word slot by slot; check the previous word along the way.
    task automatic send_word(input logic [6:0] pat, input logic [W-1:0] data, input logic pd);
        logic [W-1:0] held;
        held = '0;
        for (int j = 0; j < SLOTS; j++) begin
            @(negedge clk_bit);
            if (j == 0) begin
                pwr_n = !pd;
                if (pd) begin
                    m_lock  = 1'b0;
                    m_match = 0;
                    m_miss  = 0;
                    m_word  = '0;
                end
            end
            if (j == 1) begin
                check({ptag, m_lock ? " R1 word" : " R3 word"}, 32'(word_o), 32'(m_word));
                check({ptag, " R2 locked"}, 32'(locked_o), 32'(m_lock));
                check({ptag, " R6 clk high slot1"}, 32'(word_clk_o), 32'(m_lock));
                held = word_o;
            end
            if (j == 3) begin
                check({ptag, " R6 clk high slot3"}, 32'(word_clk_o), 32'(m_lock));
            end
            if (j == 5) begin
                check({ptag, " R6 clk low slot5"}, 32'(word_clk_o), 32'd0);
                check({ptag, " R5 word held"}, 32'(word_o), 32'(held));
            end
            frame_ser = pat[j];
            for (int k = 0; k < LANES; k++) begin
                data_ser[k] = data[k*SLOTS + j];
            end
        end
        if (!pd) begin
            model_word(pat, data);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        return W'($urandom);
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk_bit);
        check("R3 reset word", 32'(word_o), 32'd0);
        check("R3 reset lock", 32'(locked_o), 32'd0);
        check("R3 reset clk", 32'(word_clk_o), 32'd0);
        rst_n = 1'b1;

        // R2: three framed words do not lock, the fourth does.
        ptag = "R2";
        for (int i = 0; i < 4; i++) send_word(SHAPE, rnd_word(), 1'b0);

        // R8: first delivered word is the one after the fourth framed word.
        ptag = "R8";
        send_word(SHAPE, 28'hA5C3E71, 1'b0);
        send_word(SHAPE, 28'h0000001, 1'b0);

        // R1: walking ones and lane patterns check slot-to-bit mapping.
        ptag = "R1";
        for (int b = 0; b < W; b += 3) send_word(SHAPE, W'(1) << b, 1'b0);
        send_word(SHAPE, 28'h8000000, 1'b0);
        send_word(SHAPE, 28'h000007F, 1'b0);
        send_word(SHAPE, 28'hFE00000, 1'b0);
        for (int i = 0; i < 12; i++) send_word(SHAPE, rnd_word(), 1'b0);

        // R4: a single miss keeps lock and delivers the data.
        ptag = "R4";
        send_word(NOSHAPE, 28'h1234567, 1'b0);
        send_word(SHAPE, rnd_word(), 1'b0);
        send_word(SHAPE, rnd_word(), 1'b0);
        // R4: two misses in a row drop lock.
        send_word(NOSHAPE, rnd_word(), 1'b0);
        send_word(NOSHAPE, rnd_word(), 1'b0);
        send_word(SHAPE, rnd_word(), 1'b0);

        // R2: a miss during alignment restarts the count.
        ptag = "R2";
        send_word(SHAPE, rnd_word(), 1'b0);
        send_word(SHAPE, rnd_word(), 1'b0);
        send_word(NOSHAPE, rnd_word(), 1'b0);
        for (int i = 0; i < 6; i++) send_word(SHAPE, rnd_word(), 1'b0);

        // R7: power-down silences outputs; relock needs four new words.
        ptag = "R7";
        for (int i = 0; i < 3; i++) send_word(SHAPE, rnd_word(), 1'b1);
        for (int i = 0; i < 7; i++) send_word(SHAPE, rnd_word(), 1'b0);
        send_word(SHAPE, '0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule